// File: doc/BRIEF.md
# MMU Access Check and Fault Logger

This block sits beside a page table walker and a TLB fill path. For each translation request it receives the final entry's 3-bit permission code, the 3-bit access index of the request, the entry's modified bit, the page's virtual address and any error found by the walker. It decides whether the access is allowed, waived, logged quietly or trapped. It produces the protection flags to install in the TLB, and it keeps a fault status register and a fault address register. The CPU reads both registers through a small register port.

Requests arrive on a valid-qualified input with no back-pressure. The block accepts one check in every cycle that `chk_valid` is high, so there is no ready signal. Each result appears one cycle later as a single-cycle `res_valid` pulse. The trap pulses are aligned with that result. Register reads are combinational. A read of the status register clears it at the next clock edge.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index encodes bit 0 = supervisor, bit 1 = instruction fetch, bit 2 = write. A write needs write right and a fetch needs execute right; an index with both bits needs both. An index with neither bit is a load and needs read right. A user request with permission code 6 or 7 is a privilege error (fault type 3). Any other missing right is a protection error (fault type 2).
- R2: The rights of a code, as {execute, write, read} on `res_prot[2:0]`, are the same for both modes for codes 0 to 4: R, RW, RX, RWX, X. For codes 5, 6 and 7 a supervisor gets RW, RX and RWX, while a user gets R, none and none. A granted, unfaulted access returns these rights.
- R3: On a granted, unfaulted access, the write flag is cleared whenever `chk_modified` is low.
- R4: A permission error from a user request while `no_fault_mode` is high is ignored. The access is granted with its normal flags and nothing is logged.
- R5: A logged fault writes the status register with these fields: bit 1 = address valid, bits 4:2 = fault type, bits 7:5 = access index, bits 9:8 = walk level.
- R6: If the status register is nonzero when a fault is logged, all its earlier bits are dropped and bit 0 (overflow) is set before the new fields are ORed in.
- R7: A logged fault loads the fault address register with the virtual address with its page-offset bits cleared.
- R8: A logged fault while `no_fault_mode` is high or `traps_enabled` is low raises no trap. The access is granted with all three flags set.
- R9: A logged fault otherwise denies the access with all flags clear. It pulses `trap_ifetch` for a fetch index, or `trap_data` for any other index, for one cycle together with `res_valid`.
- R10: Reading the status register (`reg_sel`=0) returns its value and clears it at the next edge. A fault logged at that same edge is written on top of the cleared value, so it sets no overflow. Reading the address register (`reg_sel`=1) changes nothing.
- R11: When `walk_err` is high, the permission check is skipped. A fault is logged with type `walk_ftype` (1 invalid entry, 4 translation error) and level `walk_level`. It follows R8 and R9 for the trap decision.
- R12: After reset, both registers read zero and `res_valid`, `trap_ifetch` and `trap_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_valid | input | 1 | A check request is present this cycle |
| chk_acc_idx | input | 3 | Access index: bit 0 supervisor, bit 1 fetch, bit 2 write |
| chk_perm | input | 3 | Permission code of the final entry |
| chk_modified | input | 1 | Modified bit of the final entry |
| chk_vaddr | input | ADDR_W | Virtual address of the access |
| walk_err | input | 1 | The walker failed for this request |
| walk_ftype | input | 3 | Walker fault type |
| walk_level | input | 2 | Table level at which the walker failed |
| no_fault_mode | input | 1 | No-fault mode enable |
| traps_enabled | input | 1 | Traps are enabled |
| res_valid | output | 1 | Result pulse, one cycle after `chk_valid` |
| res_grant | output | 1 | The TLB fill may proceed |
| res_prot | output | 3 | Flags {execute, write, read} for the fill |
| trap_ifetch | output | 1 | Instruction fault pulse |
| trap_data | output | 1 | Data fault pulse |
| reg_rd_en | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 status register, 1 address register |
| reg_rdata | output | ADDR_W | Read data, combinational |

## Verification
The result, flags and trap pulses are registered once. They are due in the cycle after the one in which `chk_valid` is high. The bench drives each request on a falling edge and checks the outputs on the next falling edge, one rising edge later. The register port is combinational, so the bench compares read data a few nanoseconds after the falling edge that applies `reg_rd_en`, before the clearing edge. Its model applies the clear and any fault logged at that same edge together, so register values are checked on the cycle after each fault or read.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

  // Access index bit positions
  localparam int unsigned ACC_SUP_BIT   = 0;
  localparam int unsigned ACC_FETCH_BIT = 1;
  localparam int unsigned ACC_WRITE_BIT = 2;

  // Protection flag bit positions
  localparam int unsigned PROT_R = 0;
  localparam int unsigned PROT_W = 1;
  localparam int unsigned PROT_X = 2;

  // Status register field positions (software decodes these)
  localparam int unsigned FS_OVF_BIT  = 0;
  localparam int unsigned FS_VAL_BIT  = 1;
  localparam int unsigned FS_TYPE_LO  = 2;
  localparam int unsigned FS_ACC_LO   = 5;
  localparam int unsigned FS_LVL_LO   = 8;
  localparam int unsigned FS_USED_W   = 10;

  typedef enum logic [2:0] {
    FT_NONE    = 3'd0,
    FT_INVALID = 3'd1,
    FT_PROT    = 3'd2,
    FT_PRIV    = 3'd3,
    FT_XLATE   = 3'd4
  } fault_type_e;

  typedef struct packed {
    logic       grant;
    logic [2:0] prot;
    logic       trap_i;
    logic       trap_d;
  } verdict_t;

  // Rights granted by a permission code, {X,W,R}
  function automatic logic [2:0] code_rights(input logic sup, input logic [2:0] code);
    logic [2:0] r;
    case (code)
      3'd0: r = 3'b001;
      3'd1: r = 3'b011;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b100;
      3'd5: r = sup ? 3'b011 : 3'b001;
      3'd6: r = sup ? 3'b101 : 3'b000;
      default: r = sup ? 3'b111 : 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mmu_perm_decode.sv
module mmu_perm_decode
  import mmu_guard_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic [2:0]        acc_idx,
  input  logic [CODE_W-1:0] perm,
  input  logic              modified,
  output fault_type_e       perm_ftype,
  output logic [2:0]        perm_prot
);

  logic       sup;
  logic [2:0] rights;
  logic [2:0] needed;

  always_comb begin
    sup    = acc_idx[ACC_SUP_BIT];
    rights = code_rights(sup, perm[2:0]);
    needed = '0;
    needed[PROT_W] = acc_idx[ACC_WRITE_BIT];
    needed[PROT_X] = acc_idx[ACC_FETCH_BIT];
    needed[PROT_R] = !acc_idx[ACC_WRITE_BIT] && !acc_idx[ACC_FETCH_BIT];

    if (!sup && perm[2:1] == 2'b11)
      perm_ftype = FT_PRIV;
    else if ((needed & ~rights) != 3'b000)
      perm_ftype = FT_PROT;
    else
      perm_ftype = FT_NONE;

    perm_prot = rights;
    if (!modified)
      perm_prot[PROT_W] = 1'b0;
  end

endmodule

// File: rtl/mmu_fault_policy.sv
module mmu_fault_policy
  import mmu_guard_pkg::*;
(
  input  logic        chk_valid,
  input  logic [2:0]  acc_idx,
  input  fault_type_e perm_ftype,
  input  logic [2:0]  perm_prot,
  input  logic        walk_err,
  input  logic [2:0]  walk_ftype,
  input  logic [1:0]  walk_level,
  input  logic        no_fault_mode,
  input  logic        traps_enabled,
  output logic        log_fault,
  output logic [2:0]  log_ftype,
  output logic [1:0]  log_level,
  output verdict_t    verdict
);

  logic perm_err;
  logic waived;
  logic quiet;

  always_comb begin
    perm_err  = (perm_ftype != FT_NONE);
    waived    = !walk_err && perm_err && no_fault_mode && !acc_idx[ACC_SUP_BIT];
    log_fault = chk_valid && (walk_err || (perm_err && !waived));
    log_ftype = walk_err ? walk_ftype : 3'(perm_ftype);
    log_level = walk_err ? walk_level : 2'd0;
    quiet     = no_fault_mode || !traps_enabled;

    verdict.grant  = !log_fault || quiet;
    verdict.prot   = log_fault ? (quiet ? 3'b111 : 3'b000) : perm_prot;
    verdict.trap_i = log_fault && !quiet && acc_idx[ACC_FETCH_BIT];
    verdict.trap_d = log_fault && !quiet && !acc_idx[ACC_FETCH_BIT];
  end

endmodule

// File: rtl/mmu_fault_log.sv
module mmu_fault_log
  import mmu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_fault,
  input  logic [2:0]        log_acc,
  input  logic [2:0]        log_ftype,
  input  logic [1:0]        log_level,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              clr_status,
  output logic [ADDR_W-1:0] fsr_q,
  output logic [ADDR_W-1:0] far_q
);

  localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W'(1) << PAGE_BITS) - ADDR_W'(1));

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] fsr_nxt;

  always_comb begin
    base    = clr_status ? '0 : fsr_q;
    fsr_nxt = base;
    if (log_fault) begin
      fsr_nxt = '0;
      fsr_nxt[FS_OVF_BIT]                = (base != '0);
      fsr_nxt[FS_VAL_BIT]                = 1'b1;
      fsr_nxt[FS_TYPE_LO +: 3]           = log_ftype;
      fsr_nxt[FS_ACC_LO +: 3]            = log_acc;
      fsr_nxt[FS_LVL_LO +: 2]            = log_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsr_q <= '0;
      far_q <= '0;
    end else begin
      fsr_q <= fsr_nxt;
      if (log_fault)
        far_q <= vaddr & PAGE_MASK;
    end
  end

endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [2:0]        chk_acc_idx,
  input  logic [2:0]        chk_perm,
  input  logic              chk_modified,
  input  logic [ADDR_W-1:0] chk_vaddr,
  input  logic              walk_err,
  input  logic [2:0]        walk_ftype,
  input  logic [1:0]        walk_level,
  input  logic              no_fault_mode,
  input  logic              traps_enabled,
  output logic              res_valid,
  output logic              res_grant,
  output logic [2:0]        res_prot,
  output logic              trap_ifetch,
  output logic              trap_data,
  input  logic              reg_rd_en,
  input  logic              reg_sel,
  output logic [ADDR_W-1:0] reg_rdata
);

  fault_type_e       perm_ftype;
  logic [2:0]        perm_prot;
  logic              log_fault;
  logic [2:0]        log_ftype;
  logic [1:0]        log_level;
  verdict_t          verdict;
  logic [ADDR_W-1:0] fsr_cur;
  logic [ADDR_W-1:0] far_cur;

  mmu_perm_decode #(.CODE_W(3)) u_decode (
    .acc_idx    (chk_acc_idx),
    .perm       (chk_perm),
    .modified   (chk_modified),
    .perm_ftype (perm_ftype),
    .perm_prot  (perm_prot)
  );

  mmu_fault_policy u_policy (
    .chk_valid     (chk_valid),
    .acc_idx       (chk_acc_idx),
    .perm_ftype    (perm_ftype),
    .perm_prot     (perm_prot),
    .walk_err      (walk_err),
    .walk_ftype    (walk_ftype),
    .walk_level    (walk_level),
    .no_fault_mode (no_fault_mode),
    .traps_enabled (traps_enabled),
    .log_fault     (log_fault),
    .log_ftype     (log_ftype),
    .log_level     (log_level),
    .verdict       (verdict)
  );

  mmu_fault_log #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_log (
    .clk        (clk),
    .rst_n      (rst_n),
    .log_fault  (log_fault),
    .log_acc    (chk_acc_idx),
    .log_ftype  (log_ftype),
    .log_level  (log_level),
    .vaddr      (chk_vaddr),
    .clr_status (reg_rd_en && !reg_sel),
    .fsr_q      (fsr_cur),
    .far_q      (far_cur)
  );

  assign reg_rdata = reg_sel ? far_cur : fsr_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_grant   <= 1'b0;
      res_prot    <= '0;
      trap_ifetch <= 1'b0;
      trap_data   <= 1'b0;
    end else begin
      res_valid   <= chk_valid;
      res_grant   <= chk_valid && verdict.grant;
      res_prot    <= chk_valid ? verdict.prot : 3'b000;
      trap_ifetch <= verdict.trap_i;
      trap_data   <= verdict.trap_d;
    end
  end

endmodule

// File: rtl/mmu_access_guard_props.sv
module mmu_access_guard_props #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chk_valid,
  input logic [2:0]        chk_acc_idx,
  input logic              chk_modified,
  input logic              no_fault_mode,
  input logic              traps_enabled,
  input logic              res_valid,
  input logic              res_grant,
  input logic [2:0]        res_prot,
  input logic              trap_ifetch,
  input logic              trap_data,
  input logic              reg_rd_en,
  input logic              reg_sel,
  input logic              log_fault,
  input logic [ADDR_W-1:0] fsr_cur
);

  // R9
  trap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ifetch, trap_data}));

  // R9
  trap_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ifetch || trap_data) |-> (res_valid && !res_grant && res_prot == 3'b000));

  // R9
  trap_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_acc_idx[1]) |=> !trap_ifetch);

  // R8
  quiet_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && (no_fault_mode || !traps_enabled)) |=> (!trap_ifetch && !trap_data));

  // R5
  fsr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_fault |=> fsr_cur[1]);

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !reg_sel && !log_fault) |=> (fsr_cur == '0));

  // R3
  wr_withheld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !chk_modified) |=> !(res_grant && res_prot[1] && res_prot != 3'b111));

  // R12
  idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !res_valid);

endmodule

bind mmu_access_guard mmu_access_guard_props #(.ADDR_W(ADDR_W)) u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .chk_valid     (chk_valid),
  .chk_acc_idx   (chk_acc_idx),
  .chk_modified  (chk_modified),
  .no_fault_mode (no_fault_mode),
  .traps_enabled (traps_enabled),
  .res_valid     (res_valid),
  .res_grant     (res_grant),
  .res_prot      (res_prot),
  .trap_ifetch   (trap_ifetch),
  .trap_data     (trap_data),
  .reg_rd_en     (reg_rd_en),
  .reg_sel       (reg_sel),
  .log_fault     (log_fault),
  .fsr_cur       (fsr_cur)
);

// File: tb/mmu_access_guard_tb_top.sv
`timescale 1ns/1ps
module mmu_access_guard_tb_top;

  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chk_valid = 1'b0;
  logic [2:0]    chk_acc_idx = '0;
  logic [2:0]    chk_perm = '0;
  logic          chk_modified = 1'b0;
  logic [AW-1:0] chk_vaddr = '0;
  logic          walk_err = 1'b0;
  logic [2:0]    walk_ftype = '0;
  logic [1:0]    walk_level = '0;
  logic          no_fault_mode = 1'b0;
  logic          traps_enabled = 1'b1;
  logic          res_valid, res_grant, trap_ifetch, trap_data;
  logic [2:0]    res_prot;
  logic          reg_rd_en = 1'b0;
  logic          reg_sel = 1'b0;
  logic [AW-1:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] m_fsr = '0;
  logic [AW-1:0] m_far = '0;
  bit done = 0;

  always #10 clk = ~clk;

  mmu_access_guard #(.ADDR_W(AW), .PAGE_BITS(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_acc_idx(chk_acc_idx),
    .chk_perm(chk_perm), .chk_modified(chk_modified), .chk_vaddr(chk_vaddr),
    .walk_err(walk_err), .walk_ftype(walk_ftype), .walk_level(walk_level),
    .no_fault_mode(no_fault_mode), .traps_enabled(traps_enabled),
    .res_valid(res_valid), .res_grant(res_grant), .res_prot(res_prot),
    .trap_ifetch(trap_ifetch), .trap_data(trap_data),
    .reg_rd_en(reg_rd_en), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
  );

  // Expected error code per access index row and permission code column
  function automatic logic [3:0] exp_code(input logic [2:0] row, input logic [2:0] col);
    logic [31:0] r;
    case (row)
      3'd0: r = 32'hCC08_0000;
      3'd1: r = 32'h0008_0000;
      3'd2: r = 32'hCC80_0088;
      3'd3: r = 32'h0080_0088;
      3'd4: r = 32'hCC88_0808;
      3'd5: r = 32'h0808_0808;
      3'd6: r = 32'hCC88_0888;
      default: r = 32'h0888_0888;
    endcase
    return r[col*4 +: 4];
  endfunction

  function automatic logic [2:0] exp_rights(input logic sup, input logic [2:0] code);
    logic [2:0] u [8];
    logic [2:0] s [8];
    u = '{3'b001, 3'b011, 3'b101, 3'b111, 3'b100, 3'b001, 3'b000, 3'b000};
    s = '{3'b001, 3'b011, 3'b101, 3'b111, 3'b100, 3'b011, 3'b101, 3'b111};
    return sup ? s[code] : u[code];
  endfunction

  task automatic fail_line(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic cmp(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) fail_line(req, what, act, exp);
  endtask

  // Called at a falling edge; drives one check, optional simultaneous status read.
  task automatic do_check(input string req, input logic [2:0] acc, input logic [2:0] perm,
                          input logic mod, input logic [AW-1:0] va, input logic we,
                          input logic [2:0] wt, input logic [1:0] wl, input logic nf,
                          input logic ten, input logic rd_status);
    logic [3:0] code;
    logic waive, fault, quiet, gnt, ti, td;
    logic [2:0] prot;
    logic [AW-1:0] base;
    chk_valid = 1'b1; chk_acc_idx = acc; chk_perm = perm; chk_modified = mod;
    chk_vaddr = va; walk_err = we; walk_ftype = wt; walk_level = wl;
    no_fault_mode = nf; traps_enabled = ten;
    reg_rd_en = rd_status; reg_sel = 1'b0;
    code  = exp_code(acc, perm);
    waive = !we && code != 0 && nf && !acc[0];
    fault = we || (code != 0 && !waive);
    quiet = nf || !ten;
    gnt   = !fault || quiet;
    prot  = fault ? (quiet ? 3'b111 : 3'b000) : (exp_rights(acc[0], perm) & (mod ? 3'b111 : 3'b101));
    ti    = fault && !quiet && acc[1];
    td    = fault && !quiet && !acc[1];
    if (rd_status) begin
      #2 cmp("R10", "status read", reg_rdata, m_fsr);
    end
    base = rd_status ? '0 : m_fsr;
    if (fault) begin
      m_fsr = {22'd0, (we ? wl : 2'd0), acc, (we ? wt : code[3:2] == 2'd2 ? 3'd2 : 3'd3), 1'b1, (base != 0)};
      m_far = va & 32'hFFFF_F000;
    end else begin
      m_fsr = base;
    end
    @(negedge clk);
    chk_valid = 1'b0; reg_rd_en = 1'b0;
    cmp(req, "res_valid", AW'(res_valid), AW'(1));
    cmp(req, "res_grant", AW'(res_grant), AW'(gnt));
    cmp(req, "res_prot", AW'(res_prot), AW'(prot));
    cmp("R9", "trap_ifetch", AW'(trap_ifetch), AW'(ti));
    cmp("R9", "trap_data", AW'(trap_data), AW'(td));
  endtask

  task automatic rd_reg(input string req, input logic sel);
    reg_rd_en = 1'b1; reg_sel = sel;
    #2 cmp(req, sel ? "address reg" : "status reg", reg_rdata, sel ? m_far : m_fsr);
    @(negedge clk);
    reg_rd_en = 1'b0;
    if (!sel) m_fsr = '0;
    cmp("R9", "no trap on idle", AW'({trap_ifetch, trap_data, res_valid}), AW'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12", "res_valid", AW'(res_valid), AW'(0));
    cmp("R12", "traps", AW'({trap_ifetch, trap_data}), AW'(0));
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg("R12", 1'b0);
    rd_reg("R12", 1'b1);

    // R1/R2: supervisor load of read-only page granted
    do_check("R1", 3'd1, 3'd0, 1'b1, 32'h1000_0ABC, 0, 0, 0, 0, 1, 0);
    // R2: supervisor code 7 store, modified
    do_check("R2", 3'd5, 3'd7, 1'b1, 32'h1000_0000, 0, 0, 0, 0, 1, 0);
    // R3: write flag withheld while modified clear
    do_check("R3", 3'd5, 3'd1, 1'b0, 32'h2000_0000, 0, 0, 0, 0, 1, 0);
    // R1/R9: user load of supervisor page -> privilege, data trap
    do_check("R1", 3'd0, 3'd6, 1'b1, 32'h1234_5678, 0, 0, 0, 0, 1, 0);
    rd_reg("R7", 1'b1);
    // R6: second fault before reading -> overflow
    do_check("R6", 3'd2, 3'd0, 1'b1, 32'h0000_3FFF, 0, 0, 0, 0, 1, 0);
    rd_reg("R6", 1'b0);
    rd_reg("R10", 1'b0);
    // R4: user protection error waived in no-fault mode
    do_check("R4", 3'd4, 3'd5, 1'b1, 32'h4444_4444, 0, 0, 0, 1, 1, 0);
    rd_reg("R4", 1'b0);
    // R8: supervisor fault in no-fault mode: full flags, logged
    do_check("R8", 3'd5, 3'd0, 1'b0, 32'h5555_5555, 0, 0, 0, 1, 1, 0);
    // R8: traps disabled
    do_check("R8", 3'd3, 3'd0, 1'b1, 32'h6666_6666, 0, 0, 0, 0, 0, 0);
    rd_reg("R8", 1'b0);
    // R11: walk error at level 2, invalid entry, fetch -> instruction trap
    do_check("R11", 3'd3, 3'd3, 1'b1, 32'h7777_7777, 1, 3'd1, 2'd2, 0, 1, 0);
    rd_reg("R11", 1'b0);
    // R10: fault and status read in same cycle -> no overflow
    do_check("R5", 3'd4, 3'd0, 1'b1, 32'h8888_8888, 0, 0, 0, 0, 1, 0);
    do_check("R10", 3'd6, 3'd0, 1'b1, 32'h9999_9999, 0, 0, 0, 0, 1, 1);
    rd_reg("R10", 1'b0);

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_check("R1", r[2:0], r[5:3], r[6], $urandom, (r[11:8] == 0), (r[12] ? 3'd4 : 3'd1),
               r[14:13], (r[17:15] == 0), (r[20:18] != 0), r[21] & r[22]);
      if (r[27:24] == 0) rd_reg("R7", 1'b1);
      if (r[31:28] == 0) rd_reg("R5", 1'b0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule